// File: doc/BRIEF.md
# Segmented Unary DAC Segment Sequencer

This block produces the switch-control words for a 10-bit segmented feedback DAC in a tracking converter. The three low code bits go to a binary-weighted group of current cells (1, 2 and 4 LSB) and are registered every clock. The upper part of the code never exists as a binary number here. It lives in two unary chains of cells. The middle chain has 7 cells worth 8 LSB each. The upper chain has 15 cells worth 64 LSB each.

The tracking counter drives the unary chains with a step-enable pulse and a direction bit. On each enabled step, exactly one cell changes state. Where a cell is the next to change, that choice comes only from the states of its neighbours in the chain. When the middle chain overflows, it clears and one upper cell turns on. When it underflows, it refills and one upper cell turns off. Because of this, no binary-to-thermometer decoder is needed, and only a few cells toggle per step.

Top module: `unary_seg_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every output is 0: binary word, middle word and upper word.
- R2: `bin_sw` equals the value `bin_in` had at the previous rising clock edge, whatever the state of the step inputs.
- R3: When `step_en` is low at a rising edge, neither thermometer word changes at that edge.
- R4: An enabled up step (`step_up`=1) while the middle word is not all ones turns on exactly one more middle cell and leaves the upper word unchanged.
- R5: An enabled up step while the middle word is all ones and the upper word is not has two effects: the middle word becomes 0, and exactly one more upper cell turns on.
- R6: An enabled down step (`step_up`=0) while the middle word is non-zero turns off exactly one middle cell and leaves the upper word unchanged.
- R7: An enabled down step while the middle word is 0 and the upper word is non-zero has two effects: the middle word becomes all ones (7'h7F), and exactly one upper cell turns off.
- R8: An up step when both words are all ones is ignored. A down step when both words are 0 is also ignored. In either case, both words keep their values.
- R9: Each thermometer word always has the form 2^k−1: cells are on contiguously from bit 0, with no gaps.
- R10: The DAC weight `bin_sw` + 8·ones(`mid_therm`) + 64·ones(`top_therm`) equals the tracked code. The tracked code is the previous-cycle `bin_in` plus 8 times the net count of non-ignored up steps since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Step request for the unary chains, one cell per asserted cycle |
| step_up | input | 1 | Step direction: 1 fills, 0 empties |
| bin_in | input | 3 | Low code bits from the tracking counter |
| bin_sw | output | 3 | Registered switch controls for the binary cells (weights 1, 2, 4) |
| mid_therm | output | 7 | Thermometer switch word for the 8 LSB cells |
| top_therm | output | 15 | Thermometer switch word for the 64 LSB cells |

## Verification
Every result of this block appears at the rising edge that samples its stimulus, and not before. That applies to the registered binary word and to both thermometer words after a step. The driver applies each stimulus on a falling edge and queues the expected words for that stimulus. The monitor reads the outputs 1 ns after the next rising edge, so each queued item is compared against exactly one register stage of latency. The expected words come from an independent count of middle and upper cells and a separately tracked unary code. This keeps the carry and borrow steps and the saturation points at both ends of the range under check in every cycle.

// File: rtl/useq_pkg.sv
package useq_pkg;

   // Operation applied to one unary chain for one clock.
   typedef enum logic [2:0] {
      CH_HOLD,
      CH_FILL,
      CH_DRAIN,
      CH_SET,
      CH_CLR
   } chain_op_e;

endpackage

// File: rtl/useq_bin_stage.sv
module useq_bin_stage #(
   parameter int W          = 3,
   parameter bit REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("useq_bin_stage: W must be at least 1");
   end

   if (REGISTERED) begin : g_reg
      logic [W-1:0] q_r;

      always_ff @(posedge clk) begin
         if (!rst_n) q_r <= '0;
         else        q_r <= d;
      end

      assign q = q_r;

      AST_BIN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (q == $past(d)));   // R2
   end else begin : g_thru
      assign q = d;
   end

endmodule

// File: rtl/useq_chain.sv
module useq_chain
   import useq_pkg::*;
#(
   parameter int N = 7
) (
   input  logic      clk,
   input  logic      rst_n,
   input  chain_op_e op,
   output logic [N-1:0] cells,
   output logic      full,
   output logic      empty
);

   localparam logic [N-1:0] ONE = N'(1);

   if (N < 2) begin : g_bad_n
      $error("useq_chain: N must be at least 2");
   end

   logic [N-1:0] cell_q;
   logic [N-1:0] cell_d;

   // Each cell looks only at its neighbours: it may turn on if the cell
   // below is on, and may turn off if the cell above is off.
   for (genvar gi = 0; gi < N; gi++) begin : g_cell
      logic below_on;
      logic above_on;

      if (gi == 0) begin : g_lo_end
         assign below_on = 1'b1;
      end else begin : g_lo_mid
         assign below_on = cell_q[gi-1];
      end

      if (gi == N-1) begin : g_hi_end
         assign above_on = 1'b0;
      end else begin : g_hi_mid
         assign above_on = cell_q[gi+1];
      end

      assign cell_d[gi] = (op == CH_CLR)   ? 1'b0 :
                          (op == CH_SET)   ? 1'b1 :
                          (op == CH_FILL)  ? (cell_q[gi] | below_on) :
                          (op == CH_DRAIN) ? (cell_q[gi] & above_on) :
                                             cell_q[gi];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cell_q <= '0;
      else        cell_q <= cell_d;
   end

   assign cells = cell_q;
   assign full  = cell_q[N-1];
   assign empty = ~cell_q[0];

   AST_CHAIN_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_q & (cell_q + ONE)) == '0);   // R9

   AST_FILL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (op == CH_FILL && !full) |=> ($countones(cell_q) == $past($countones(cell_q)) + 1));   // R4

   AST_DRAIN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (op == CH_DRAIN && !empty) |=> ($countones(cell_q) == $past($countones(cell_q)) - 1));   // R6

   AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (op == CH_CLR) |=> (cell_q == '0));   // R5

   AST_SET_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (op == CH_SET) |=> (&cell_q));   // R7

   AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (op == CH_HOLD) |=> $stable(cell_q));   // R3

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
   import useq_pkg::*;
(
   input  logic      step_en,
   input  logic      step_up,
   input  logic      mid_full,
   input  logic      mid_empty,
   input  logic      top_full,
   input  logic      top_empty,
   output chain_op_e mid_op,
   output chain_op_e top_op
);

   always_comb begin
      mid_op = CH_HOLD;
      top_op = CH_HOLD;
      if (step_en) begin
         if (step_up) begin
            if (!mid_full) begin
               mid_op = CH_FILL;
            end else if (!top_full) begin
               mid_op = CH_CLR;
               top_op = CH_FILL;
            end
         end else begin
            if (!mid_empty) begin
               mid_op = CH_DRAIN;
            end else if (!top_empty) begin
               mid_op = CH_SET;
               top_op = CH_DRAIN;
            end
         end
      end
   end

   // The upper chain only ever moves together with a middle carry or borrow.
   always_comb begin
      AST_TOP_NEEDS_CARRY: assert ((top_op == CH_HOLD) || (mid_op == CH_CLR) || (mid_op == CH_SET));   // R5
   end

endmodule

// File: rtl/unary_seg_seq.sv
module unary_seg_seq
   import useq_pkg::*;
#(
   parameter int BIN_BITS       = 3,
   parameter int MID_CELLS      = 7,
   parameter int TOP_CELLS      = 15,
   parameter bit BIN_REGISTERED = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step_en,
   input  logic                 step_up,
   input  logic [BIN_BITS-1:0]  bin_in,
   output logic [BIN_BITS-1:0]  bin_sw,
   output logic [MID_CELLS-1:0] mid_therm,
   output logic [TOP_CELLS-1:0] top_therm
);

   localparam int MID_WEIGHT = 1 << BIN_BITS;
   localparam int TOP_WEIGHT = MID_WEIGHT * (MID_CELLS + 1);
   localparam int UNARY_MAX  = MID_WEIGHT * MID_CELLS + TOP_WEIGHT * TOP_CELLS;

   if (BIN_BITS < 1 || MID_CELLS < 2 || TOP_CELLS < 2) begin : g_bad_cfg
      $error("unary_seg_seq: segment sizes out of range");
   end
   if (MID_CELLS != (1 << BIN_BITS) - 1) begin : g_bad_ratio
      $error("unary_seg_seq: middle chain must hold 2**BIN_BITS-1 cells");
   end

   chain_op_e mid_op;
   chain_op_e top_op;
   logic      mid_full, mid_empty, top_full, top_empty;

   useq_bin_stage #(
      .W          (BIN_BITS),
      .REGISTERED (BIN_REGISTERED)
   ) u_bin (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bin_in),
      .q     (bin_sw)
   );

   useq_ctrl u_ctrl (
      .step_en   (step_en),
      .step_up   (step_up),
      .mid_full  (mid_full),
      .mid_empty (mid_empty),
      .top_full  (top_full),
      .top_empty (top_empty),
      .mid_op    (mid_op),
      .top_op    (top_op)
   );

   useq_chain #(.N(MID_CELLS)) u_mid (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (mid_op),
      .cells (mid_therm),
      .full  (mid_full),
      .empty (mid_empty)
   );

   useq_chain #(.N(TOP_CELLS)) u_top (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (top_op),
      .cells (top_therm),
      .full  (top_full),
      .empty (top_empty)
   );

   int unary_wt;
   assign unary_wt = MID_WEIGHT * $countones(mid_therm) + TOP_WEIGHT * $countones(top_therm);

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> ($stable(mid_therm) && $stable(top_therm)));   // R3

   AST_UP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && step_up && (&mid_therm) && !(&top_therm))
      |=> (mid_therm == '0 && $countones(top_therm) == $past($countones(top_therm)) + 1));   // R5

   AST_DN_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !step_up && mid_therm == '0 && top_therm != '0)
      |=> ((&mid_therm) && $countones(top_therm) == $past($countones(top_therm)) - 1));   // R7

   AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && step_up && (&mid_therm) && (&top_therm))
      |=> ($stable(mid_therm) && $stable(top_therm)));   // R8

   AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !step_up && mid_therm == '0 && top_therm == '0)
      |=> ($stable(mid_therm) && $stable(top_therm)));   // R8

   AST_UP_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && step_up && unary_wt < UNARY_MAX)
      |=> (unary_wt == $past(unary_wt) + MID_WEIGHT));   // R10

   AST_DN_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !step_up && unary_wt > 0)
      |=> (unary_wt == $past(unary_wt) - MID_WEIGHT));   // R10

endmodule

// File: tb/unary_seg_seq_bench.sv
module unary_seg_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        step_en;
   logic        step_up;
   logic [2:0]  bin_in;
   logic [2:0]  bin_sw;
   logic [6:0]  mid_therm;
   logic [14:0] top_therm;

   always #5 clk = ~clk;

   unary_seg_seq u_unary_seg_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_en   (step_en),
      .step_up   (step_up),
      .bin_in    (bin_in),
      .bin_sw    (bin_sw),
      .mid_therm (mid_therm),
      .top_therm (top_therm)
   );

   typedef struct {
      int    bin;
      int    mc;
      int    tc;
      int    ucode;
      string req;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   int   mc = 0;
   int   tc = 0;
   int   ucode = 0;
   bit   done = 1'b0;

   task automatic chk(string req, int act, int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Driver: apply one stimulus at a falling edge and queue its expected result.
   task automatic drive(bit en, bit up, int b);
      string tag;
      @(negedge clk);
      step_en = en;
      step_up = up;
      bin_in  = 3'(b);
      tag = "R3";
      if (en && up) begin
         if (ucode >= 1016)  tag = "R8";
         else if (mc < 7)    begin tag = "R4"; mc++; ucode += 8; end
         else                begin tag = "R5"; mc = 0; tc++; ucode += 8; end
      end else if (en && !up) begin
         if (ucode <= 0)     tag = "R8";
         else if (mc > 0)    begin tag = "R6"; mc--; ucode -= 8; end
         else                begin tag = "R7"; mc = 7; tc--; ucode -= 8; end
      end
      exp_q.push_back('{b, mc, tc, ucode, tag});
   endtask

   // Monitor: one register stage after each stimulus, compare and pop.
   always begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         chk({e.req, " mid word"}, int'(mid_therm), (1 << e.mc) - 1);
         chk({e.req, " top word"}, int'(top_therm), (1 << e.tc) - 1);
         chk("R2 binary word", int'(bin_sw), e.bin);
         chk("R9 mid contiguous", int'((8'(mid_therm) & (8'(mid_therm) + 8'd1)) == 8'd0), 1);
         chk("R9 top contiguous", int'((16'(top_therm) & (16'(top_therm) + 16'd1)) == 16'd0), 1);
         chk("R10 total weight",
             int'(bin_sw) + 8 * $countones(mid_therm) + 64 * $countones(top_therm),
             e.bin + e.ucode);
      end
   end

   task automatic apply_reset();
      repeat (2) @(negedge clk);
      rst_n   = 1'b0;
      step_en = 1'b1;
      step_up = 1'b1;
      bin_in  = 3'd6;
      repeat (3) @(negedge clk);
      chk("R1 bin in reset", int'(bin_sw), 0);
      chk("R1 mid in reset", int'(mid_therm), 0);
      chk("R1 top in reset", int'(top_therm), 0);
      step_en = 1'b0;
      bin_in  = 3'd0;
      mc = 0; tc = 0; ucode = 0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 bin after release", int'(bin_sw), 0);
      chk("R1 mid after release", int'(mid_therm), 0);
      chk("R1 top after release", int'(top_therm), 0);
   endtask

   initial begin
      rst_n   = 1'b0;
      step_en = 1'b0;
      step_up = 1'b0;
      bin_in  = 3'd0;
      apply_reset();

      // Idle cycles with varying low bits (R2, R3)
      drive(0, 1, 5);
      drive(0, 0, 2);
      drive(0, 1, 7);
      // Down at zero is ignored (R8)
      drive(1, 0, 1);
      // Fill middle chain then carry (R4, R5), up to full scale
      for (int i = 0; i < 127; i++) drive(1, 1, i % 8);
      // Up at full scale ignored (R8)
      drive(1, 1, 7);
      drive(1, 1, 7);
      drive(0, 1, 3);
      // Drain all the way down (R6, R7) then extra downs (R8)
      for (int i = 0; i < 127; i++) drive(1, 0, (i * 3) % 8);
      drive(1, 0, 0);
      drive(1, 0, 4);

      // Mixed pattern from a small LFSR
      begin
         logic [7:0] lf = 8'hA5;
         for (int i = 0; i < 300; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            drive(lf[0] | lf[1], lf[2] | (i < 150 ? lf[3] : 1'b0), int'(lf[7:5]));
         end
      end

      // Reset while stepping returns to minimum (R1)
      apply_reset();
      drive(1, 1, 2);
      drive(1, 0, 0);

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) chk("R10 queue drained", exp_q.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule